// File: doc/BRIEF.md
# Receive Timestamp Pairing Unit

This unit sits on the receive path toward a host processor and joins timestampable link-local frames with the timestamps that reach it separately. The switch fabric does not place the capture time inside the frame. Instead it sends a small metadata frame right after each timestampable frame, and that metadata frame carries a truncated copy of the capture time. The switch guarantees that nothing else heading to the host lands between the two, so the unit pairs them purely by arrival order. It does this with one state machine that serves every port.

Each input beat is one frame descriptor with its address and EtherType fields, a classification flag, and the partial timestamp lane. When a timestampable frame arrives, the unit keeps its descriptor and waits. When the metadata frame that follows arrives, the unit sends out the kept descriptor. It widens the partial timestamp to full width using a free-running time input and drives it as sideband data. The metadata frame itself is consumed and never sent out. Ordinary frames pass through with one cycle of latency.

Software clears the enable input while it reconfigures timestamp capture. While enable is low, metadata frames are discarded without touching the pairing state, and timestampable frames are sent on as ordinary traffic.

Top module: `rxts_pairer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `out_stamp_ok` and `out_missed` are 0 and `orphan_cnt` is 0. The unit starts with nothing held.
- R2: An input beat that is neither a metadata frame nor a timestampable frame with enable high appears on the output one cycle later. Its descriptor is unchanged, and `out_stamp_ok` and `out_missed` are 0.
- R3: A beat is a metadata frame only when all three fields match at once: DMAC 48'h0AFE0000005A, SMAC 48'h025453000001 and EtherType 16'hD7A1. A metadata frame never appears on the output. A beat that matches only some of these fields is treated as ordinary traffic.
- R4: A timestampable frame (`in_tsable` = 1 with enable high) that arrives while nothing is held produces no output and is held.
- R5: A metadata frame with enable high that arrives while a frame is held releases the held descriptor one cycle later with `out_stamp_ok` = 1. The unit then holds nothing.
- R6: The released timestamp is the partial value placed in the low PART_W bits. The upper bits are taken from `now_time` in the cycle the metadata frame arrives, minus one when the partial value is greater than the low PART_W bits of `now_time`. The upper bits wrap modulo their width.
- R7: A second timestampable frame that arrives while a frame is held releases the earlier one one cycle later with `out_missed` = 1 and `out_stamp_ok` = 0. The new frame is then held.
- R8: A metadata frame with enable high that arrives while nothing is held produces no output. It increments `orphan_cnt`, which saturates at all ones.
- R9: With enable low, a metadata frame produces no output and leaves both the held frame and `orphan_cnt` unchanged.
- R10: An ordinary frame that arrives while a frame is held passes through (R2) and leaves the held frame in place for the next metadata frame.
- R11: With enable low, a timestampable frame passes through as ordinary traffic.
- R12: `out_valid` is 1 only in the cycle after an input beat. `out_stamp_ok` and `out_missed` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ts_en | input | 1 | Receive timestamp pairing enable |
| now_time | input | TIME_W | Free-running time used to widen partial stamps |
| in_valid | input | 1 | Input descriptor beat present |
| in_dmac | input | 48 | Destination MAC of the frame |
| in_smac | input | 48 | Source MAC of the frame |
| in_etype | input | 16 | EtherType of the frame |
| in_tsable | input | 1 | Frame is a timestampable link-local frame |
| in_desc | input | DESC_W | Frame descriptor |
| in_part_ts | input | PART_W | Partial timestamp carried by a metadata frame |
| out_valid | output | 1 | Output descriptor beat present |
| out_desc | output | DESC_W | Output frame descriptor |
| out_stamp | output | TIME_W | Full timestamp, meaningful when out_stamp_ok |
| out_stamp_ok | output | 1 | Descriptor carries a paired timestamp |
| out_missed | output | 1 | Held frame released without a timestamp |
| orphan_cnt | output | CNT_W | Saturating count of metadata frames with nothing held |

## Verification
Directed sequences cover the pairing orders one at a time, and each has a distinct signature on the output:
- hold then metadata;
- hold, hold, then metadata;
- hold, ordinary frame, then metadata;
- hold, metadata with enable low, then metadata with enable high;
- metadata with nothing held.

Widening is tried with the partial value below, equal to and above the low bits of the current time, and with upper bits of zero. This separates a correct borrow from an off-by-one comparison and from a missing wrap. Beats that match only some of the identification fields show whether every field is really compared. A long run of seeded random beat kinds, enable values and times is then checked against a reference model, followed by enough orphans to reach counter saturation.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

    localparam logic [47:0] META_DMAC  = 48'h0AFE0000005A;
    localparam logic [47:0] META_SMAC  = 48'h025453000001;
    localparam logic [15:0] META_ETYPE = 16'hD7A1;

    typedef enum logic [1:0] {
        KIND_PASS = 2'd0,
        KIND_HOLD = 2'd1,
        KIND_META = 2'd2
    } beat_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pair_state_t;

    function automatic logic is_meta_hdr(input logic [47:0] dmac,
                                         input logic [47:0] smac,
                                         input logic [15:0] etype);
        return (dmac == META_DMAC) && (smac == META_SMAC) && (etype == META_ETYPE);
    endfunction

endpackage

// File: rtl/rxts_classify.sv
module rxts_classify
    import rxts_pkg::*;
(
    input  logic [47:0] dmac,
    input  logic [47:0] smac,
    input  logic [15:0] etype,
    input  logic        tsable,
    input  logic        en,
    output beat_kind_t  kind
);
    always_comb begin
        if (is_meta_hdr(dmac, smac, etype))
            kind = KIND_META;
        else if (tsable && en)
            kind = KIND_HOLD;
        else
            kind = KIND_PASS;
    end
endmodule

// File: rtl/rxts_rebuild.sv
module rxts_rebuild #(
    parameter int TIME_W = 32,
    parameter int PART_W = 24
) (
    input  logic [PART_W-1:0] part,
    input  logic [TIME_W-1:0] now,
    output logic [TIME_W-1:0] full
);
    localparam int HI_W = TIME_W - PART_W;

    logic [HI_W-1:0] hi_now;
    logic [HI_W-1:0] hi_fix;
    logic            borrow;

    assign hi_now = now[TIME_W-1:PART_W];
    assign borrow = part > now[PART_W-1:0];
    assign hi_fix = borrow ? hi_now - HI_W'(1) : hi_now;
    assign full   = {hi_fix, part};
endmodule

// File: rtl/rxts_pair_fsm.sv
module rxts_pair_fsm
    import rxts_pkg::*;
#(
    parameter int DESC_W = 16,
    parameter int TIME_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  beat_kind_t        kind,
    input  logic [DESC_W-1:0] in_desc,
    input  logic [TIME_W-1:0] stamp,
    output logic              out_valid,
    output logic [DESC_W-1:0] out_desc,
    output logic [TIME_W-1:0] out_stamp,
    output logic              out_stamp_ok,
    output logic              out_missed,
    output logic [CNT_W-1:0]  orphan_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pair_state_t       state;
    logic [DESC_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            held         <= '0;
            out_valid    <= 1'b0;
            out_desc     <= '0;
            out_stamp    <= '0;
            out_stamp_ok <= 1'b0;
            out_missed   <= 1'b0;
            orphan_cnt   <= '0;
        end else begin
            out_valid    <= 1'b0;
            out_stamp_ok <= 1'b0;
            out_missed   <= 1'b0;
            if (in_valid) begin
                unique case (kind)
                    KIND_PASS: begin
                        out_valid <= 1'b1;
                        out_desc  <= in_desc;
                    end
                    KIND_HOLD: begin
                        if (state == ST_WAIT) begin
                            out_valid  <= 1'b1;
                            out_desc   <= held;
                            out_missed <= 1'b1;
                        end
                        held  <= in_desc;
                        state <= ST_WAIT;
                    end
                    KIND_META: begin
                        if (en) begin
                            if (state == ST_WAIT) begin
                                out_valid    <= 1'b1;
                                out_desc     <= held;
                                out_stamp    <= stamp;
                                out_stamp_ok <= 1'b1;
                                state        <= ST_IDLE;
                            end else if (orphan_cnt != CNT_MAX) begin
                                orphan_cnt <= orphan_cnt + CNT_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxts_pairer.sv
module rxts_pairer
    import rxts_pkg::*;
#(
    parameter int DESC_W = 16,
    parameter int TIME_W = 32,
    parameter int PART_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_ts_en,
    input  logic [TIME_W-1:0] now_time,
    input  logic              in_valid,
    input  logic [47:0]       in_dmac,
    input  logic [47:0]       in_smac,
    input  logic [15:0]       in_etype,
    input  logic              in_tsable,
    input  logic [DESC_W-1:0] in_desc,
    input  logic [PART_W-1:0] in_part_ts,
    output logic              out_valid,
    output logic [DESC_W-1:0] out_desc,
    output logic [TIME_W-1:0] out_stamp,
    output logic              out_stamp_ok,
    output logic              out_missed,
    output logic [CNT_W-1:0]  orphan_cnt
);
    beat_kind_t        kind;
    logic [TIME_W-1:0] stamp;

    rxts_classify u_cls (
        .dmac   (in_dmac),
        .smac   (in_smac),
        .etype  (in_etype),
        .tsable (in_tsable),
        .en     (rx_ts_en),
        .kind   (kind)
    );

    rxts_rebuild #(.TIME_W(TIME_W), .PART_W(PART_W)) u_reb (
        .part (in_part_ts),
        .now  (now_time),
        .full (stamp)
    );

    rxts_pair_fsm #(.DESC_W(DESC_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en           (rx_ts_en),
        .in_valid     (in_valid),
        .kind         (kind),
        .in_desc      (in_desc),
        .stamp        (stamp),
        .out_valid    (out_valid),
        .out_desc     (out_desc),
        .out_stamp    (out_stamp),
        .out_stamp_ok (out_stamp_ok),
        .out_missed   (out_missed),
        .orphan_cnt   (orphan_cnt)
    );
endmodule

// File: rtl/rxts_pairer_chk.sv
module rxts_pairer_chk
    import rxts_pkg::*;
#(
    parameter int DESC_W = 16,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_ts_en,
    input logic              in_valid,
    input logic [47:0]       in_dmac,
    input logic [47:0]       in_smac,
    input logic [15:0]       in_etype,
    input logic              in_tsable,
    input logic [DESC_W-1:0] in_desc,
    input logic              out_valid,
    input logic [DESC_W-1:0] out_desc,
    input logic              out_stamp_ok,
    input logic              out_missed,
    input logic [CNT_W-1:0]  orphan_cnt
);
    logic meta_beat;
    assign meta_beat = in_valid && is_meta_hdr(in_dmac, in_smac, in_etype);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_stamp_ok && !out_missed && orphan_cnt == '0));

    p_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !meta_beat && !(in_tsable && rx_ts_en))
        |=> (out_valid && out_desc == $past(in_desc) && !out_stamp_ok && !out_missed));

    p_orphan_only_r8: assert property (@(posedge clk) disable iff (rst)
        !(meta_beat && rx_ts_en) |=> $stable(orphan_cnt));

    p_meta_off_r9: assert property (@(posedge clk) disable iff (rst)
        (meta_beat && !rx_ts_en) |=> (!out_valid && $stable(orphan_cnt)));

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_flags_r12: assert property (@(posedge clk) disable iff (rst)
        !(out_stamp_ok && out_missed) && (out_valid || (!out_stamp_ok && !out_missed)));
endmodule

bind rxts_pairer rxts_pairer_chk #(.DESC_W(DESC_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_ts_en     (rx_ts_en),
    .in_valid     (in_valid),
    .in_dmac      (in_dmac),
    .in_smac      (in_smac),
    .in_etype     (in_etype),
    .in_tsable    (in_tsable),
    .in_desc      (in_desc),
    .out_valid    (out_valid),
    .out_desc     (out_desc),
    .out_stamp_ok (out_stamp_ok),
    .out_missed   (out_missed),
    .orphan_cnt   (orphan_cnt)
);

// File: tb/rxts_pairer_tb.sv
module rxts_pairer_tb;
    import rxts_pkg::*;

    localparam int DESC_W = 16;
    localparam int TIME_W = 32;
    localparam int PART_W = 24;
    localparam int CNT_W  = 8;
    localparam logic [47:0] OTHER_MAC = 48'h0200DEADBEEF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_ts_en = 1'b0;
    logic [TIME_W-1:0] now_time = '0;
    logic              in_valid = 1'b0;
    logic [47:0]       in_dmac = '0;
    logic [47:0]       in_smac = '0;
    logic [15:0]       in_etype = '0;
    logic              in_tsable = 1'b0;
    logic [DESC_W-1:0] in_desc = '0;
    logic [PART_W-1:0] in_part_ts = '0;
    logic              out_valid;
    logic [DESC_W-1:0] out_desc;
    logic [TIME_W-1:0] out_stamp;
    logic              out_stamp_ok;
    logic              out_missed;
    logic [CNT_W-1:0]  orphan_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic              m_wait = 1'b0;
    logic [DESC_W-1:0] m_held = '0;
    logic [CNT_W-1:0]  m_cnt = '0;

    always #2 clk = ~clk;

    rxts_pairer #(.DESC_W(DESC_W), .TIME_W(TIME_W), .PART_W(PART_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .rx_ts_en(rx_ts_en), .now_time(now_time),
        .in_valid(in_valid), .in_dmac(in_dmac), .in_smac(in_smac), .in_etype(in_etype),
        .in_tsable(in_tsable), .in_desc(in_desc), .in_part_ts(in_part_ts),
        .out_valid(out_valid), .out_desc(out_desc), .out_stamp(out_stamp),
        .out_stamp_ok(out_stamp_ok), .out_missed(out_missed), .orphan_cnt(orphan_cnt)
    );

    function automatic logic [TIME_W-1:0] ref_stamp(input logic [PART_W-1:0] p,
                                                    input logic [TIME_W-1:0] t);
        logic [PART_W-1:0] back;
        back = t[PART_W-1:0] - p;
        return t - TIME_W'(back);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one beat, advance the model, compare every output field.
    task automatic beat(input bit v, input logic [47:0] dm, input logic [47:0] sm,
                        input logic [15:0] et, input bit tsb, input bit en,
                        input logic [DESC_W-1:0] d, input logic [PART_W-1:0] p,
                        input logic [TIME_W-1:0] t, input string tag);
        bit e_v, e_ok, e_ms, mt;
        logic [DESC_W-1:0] e_d;
        logic [TIME_W-1:0] e_t;
        logic [127:0] act, exp;
        e_v = 0; e_ok = 0; e_ms = 0; e_d = '0; e_t = '0;
        mt = (dm == META_DMAC) && (sm == META_SMAC) && (et == META_ETYPE);
        if (v) begin
            if (mt) begin
                if (en) begin
                    if (m_wait) begin
                        e_v = 1; e_ok = 1; e_d = m_held; e_t = ref_stamp(p, t);
                        m_wait = 0;
                    end else if (m_cnt != '1) begin
                        m_cnt = m_cnt + 1'b1;
                    end
                end
            end else if (tsb && en) begin
                if (m_wait) begin
                    e_v = 1; e_ms = 1; e_d = m_held;
                end
                m_held = d; m_wait = 1;
            end else begin
                e_v = 1; e_d = d;
            end
        end
        @(negedge clk);
        in_valid = v; in_dmac = dm; in_smac = sm; in_etype = et; in_tsable = tsb;
        rx_ts_en = en; in_desc = d; in_part_ts = p; now_time = t;
        @(posedge clk);
        #1;
        act = {out_valid, out_stamp_ok, out_missed,
               (out_valid ? out_desc : {DESC_W{1'b0}}),
               (out_stamp_ok ? out_stamp : {TIME_W{1'b0}}), orphan_cnt};
        exp = {e_v, e_ok, e_ms, e_d, e_t, m_cnt};
        check(act == exp, tag, act, exp);
    endtask

    task automatic ord(input logic [DESC_W-1:0] d, input string tag);
        beat(1, OTHER_MAC, OTHER_MAC, 16'h0800, 0, 1, d, '0, '0, tag);
    endtask
    task automatic tsf(input logic [DESC_W-1:0] d, input bit en, input string tag);
        beat(1, 48'h0180C200000E, OTHER_MAC, 16'h88F7, 1, en, d, '0, '0, tag);
    endtask
    task automatic meta(input logic [PART_W-1:0] p, input logic [TIME_W-1:0] t,
                        input bit en, input string tag);
        beat(1, META_DMAC, META_SMAC, META_ETYPE, 0, en, 16'hEEEE, p, t, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && !out_stamp_ok && !out_missed && orphan_cnt == '0, "R1 in reset",
              {out_valid, out_stamp_ok, out_missed, orphan_cnt}, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check(!out_valid && orphan_cnt == '0, "R1 after reset",
              {out_valid, orphan_cnt}, '0);

        ord(16'h1111, "R2 ordinary");
        beat(0, '0, '0, '0, 0, 1, '0, '0, '0, "R12 idle");
        tsf(16'h2001, 1, "R4 hold");
        meta(24'h345000, 32'h12345678, 1, "R5 R6 part below low");
        tsf(16'h2002, 1, "R4 hold");
        meta(24'h350000, 32'h12345678, 1, "R6 part above low");
        tsf(16'h2003, 1, "R4 hold");
        meta(24'h00ABCD, 32'h0000ABCD, 1, "R6 part equal");
        tsf(16'h2004, 1, "R4 hold");
        meta(24'hFFFFF0, 32'h00000010, 1, "R6 wrap of upper bits");

        tsf(16'h3001, 1, "R4 hold");
        tsf(16'h3002, 1, "R7 second hold flags first");
        meta(24'h000001, 32'h55000002, 1, "R7 new frame stamped");

        tsf(16'h4001, 1, "R4 hold");
        ord(16'h4444, "R10 ordinary while held");
        meta(24'h000100, 32'h66000200, 1, "R10 held frame survives");

        tsf(16'h5001, 1, "R4 hold");
        meta(24'h000100, 32'h66000200, 0, "R9 disabled meta dropped");
        meta(24'h000100, 32'h66000200, 1, "R9 state untouched");

        beat(1, META_DMAC, META_SMAC, 16'h0800, 0, 1, 16'h6001, '0, '0, "R3 etype mismatch");
        beat(1, OTHER_MAC, META_SMAC, META_ETYPE, 0, 1, 16'h6002, '0, '0, "R3 dmac mismatch");
        beat(1, META_DMAC, OTHER_MAC, META_ETYPE, 0, 1, 16'h6003, '0, '0, "R3 smac mismatch");
        tsf(16'h7001, 0, "R11 disabled tsable passes");
        meta(24'h123456, 32'h77777777, 1, "R8 orphan counted");
        meta(24'h123456, 32'h77777777, 0, "R9 disabled orphan not counted");

        for (int i = 0; i < 3000; i++) begin
            int k;
            bit en;
            k = int'($urandom % 4);
            en = ($urandom % 8) != 0;
            case (k)
                0: beat(1, OTHER_MAC, OTHER_MAC, 16'h0800, 0, en, DESC_W'($urandom), '0, '0,
                        "R2 random");
                1: beat(1, 48'h0180C200000E, OTHER_MAC, 16'h88F7, 1, en, DESC_W'($urandom),
                        '0, '0, "R7 random");
                2: beat(1, META_DMAC, META_SMAC, META_ETYPE, 0, en, DESC_W'($urandom),
                        PART_W'($urandom), TIME_W'($urandom), "R5 random");
                default: beat(0, '0, '0, '0, 0, en, '0, '0, '0, "R12 random");
            endcase
        end

        if (m_wait) meta(24'h000000, 32'h01000000, 1, "R5 drain");
        for (int i = 0; i < 300; i++)
            meta(PART_W'(i), TIME_W'(i), 1, "R8 saturation");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule